// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a pipelined synchronous static RAM with burst addressing and single-cycle deselect. Every control, address and write-data input is captured on the rising clock edge. An access is started by one of two address strobes: a processor-side strobe that always reads, or a controller-side strobe that reads or writes depending on the write controls. Three chip selects, of mixed polarity, are looked at only on strobe cycles. Once a burst is open, the cycles where neither strobe is asserted continue it. An advance input steps a two-bit burst counter. A mode pin chooses between a linear order and an exclusive-or order for the low two address bits.

The word has four byte lanes. Each lane holds eight data bits and one parity bit. A write can cover a chosen subset of lanes, or all of them through a global write. Read data passes through an output register, so it shows up one edge after the edge that captured the address. An asynchronous output enable blanks the data, and a snooze input puts the block into a sleep state. While asleep, inputs are ignored and the data outputs are blanked.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `rdValid` is 0, `rdData` is all zeros and no burst is open, so a cycle with both strobes high performs no read.
- R2: A strobe cycle selects the device only if `selAN`=0, `selB`=1 and `selCN`=0. A strobe cycle that does not select the device closes any open burst. The output is then invalid after the next edge and stays invalid on the following non-strobe cycles.
- R3: With `selAN`=0, `procStrbN`=0 starts a read even when the write controls request a write. With `selAN`=1, `procStrbN` is ignored.
- R4: The write condition is `globalWrN`=0, or `byteWrEnN`=0 with at least one `laneWrN` bit low. Lane i occupies bits [9i+8:9i], and its parity bit is bit 9i+8. Global write stores all four lanes. Otherwise a lane is stored only when its `laneWrN` bit is 0 and `byteWrEnN` is 0.
- R5: A selected `ctrlStrbN`=0 start (with `procStrbN` high or masked) writes `wrData` to `addrIn` when the write condition holds, and reads otherwise.
- R6: Read data for an address captured at edge k is on `rdData`, with `rdValid`=1, after edge k+1.
- R7: With `burstInterleave`=0, each non-strobe cycle with `advN`=0 moves to the next address. The low two bits are (start+n) mod 4 and the upper bits stay fixed.
- R8: With `burstInterleave`=1, the low two bits of the n-th burst address are start XOR n.
- R9: A non-strobe cycle with `advN`=1 accesses the current burst address again.
- R10: A non-strobe cycle in an open burst writes the `wrData` captured on that edge to the burst address when the write condition holds.
- R11: While `outEnN`=1, `rdValid` is 0 and `rdData` is all zeros, with no clock edge needed. Clearing `outEnN` restores the held data at once.
- R12: Commands are ignored from the second edge after `snooze` rises until the second edge after it falls. The outputs are blanked while `snooze` is high or the block is asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrIn | input | ADDR_W | Word address captured on a start cycle |
| selAN | input | 1 | Chip select, active low; also masks the processor strobe |
| selB | input | 1 | Chip select, active high |
| selCN | input | 1 | Chip select, active low |
| procStrbN | input | 1 | Processor address strobe, active low, read only |
| ctrlStrbN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Enables the per-lane write bits, active low |
| laneWrN | input | LANES | Per-lane write bits, active low |
| burstInterleave | input | 1 | 0 = linear burst order, 1 = XOR burst order |
| outEnN | input | 1 | Asynchronous output enable, active low |
| snooze | input | 1 | Sleep request, active high |
| wrData | input | LANES*LANE_BITS | Write data captured with the write command |
| rdData | output | LANES*LANE_BITS | Read data, zero when not valid |
| rdValid | output | 1 | Read data valid and driven |

## Verification
Linear and XOR bursts are each started from a non-aligned address, so the two orders give different sequences and wrap-around in the low bits shows up. Suspend cycles are mixed with advancing ones to tell a held counter from a stepped one. Partial-lane writes over known data separate the global-write path from the per-lane path, and a set of lanes is left untouched to show the mask. Deselect, processor-strobe masking, output blanking and the two-edge snooze windows are each paired with a write or read that would change the observed data if the guard failed.

// File: rtl/sram_pkg.sv
package sram_pkg;
  // per-cycle decision handed from control to datapath
  typedef struct packed {
    logic access;
    logic isWrite;
  } ctlStrobes_t;
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] startLow,
  input  logic [CNT_W-1:0] count,
  input  logic             interleave,
  output logic [CNT_W-1:0] seqLow
);
  always_comb begin
    if (interleave) seqLow = startLow ^ count;
    else            seqLow = startLow + count;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              procStrbN,
  input  logic              ctrlStrbN,
  input  logic              advN,
  input  logic              globalWrN,
  input  logic              byteWrEnN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              burstInterleave,
  input  logic              snooze,
  output ctlStrobes_t       stb,
  output logic [ADDR_W-1:0] accAddr,
  output logic [LANES-1:0]  laneMask,
  output logic              sleeping
);
  localparam int SNZ_STAGES = 2;

  logic [SNZ_STAGES-1:0] snzSync;
  logic                  burstActive;
  logic [ADDR_W-1:0]     burstBase;
  logic [CNT_W-1:0]      burstCnt;
  logic [CNT_W-1:0]      nextCnt;
  logic [CNT_W-1:0]      seqLow;
  logic accept, procStart, ctrlStart, startCyc, chipSel, anyLane, wrCond;

  assign sleeping = snzSync[SNZ_STAGES-1];

  sram_burst_seq #(.CNT_W(CNT_W)) uSeq (
    .startLow  (burstBase[CNT_W-1:0]),
    .count     (nextCnt),
    .interleave(burstInterleave),
    .seqLow    (seqLow)
  );

  always_comb begin
    accept    = !sleeping;
    procStart = !procStrbN && !selAN;
    ctrlStart = !ctrlStrbN && !procStart;
    startCyc  = procStart || ctrlStart;
    chipSel   = !selAN && selB && !selCN;
    anyLane   = !(&laneWrN);
    wrCond    = !globalWrN || (!byteWrEnN && anyLane);
    nextCnt   = burstCnt + CNT_W'(!advN);
    if (!globalWrN)     laneMask = '1;
    else if (!byteWrEnN) laneMask = ~laneWrN;
    else                laneMask = '0;
    stb     = '0;
    accAddr = {burstBase[ADDR_W-1:CNT_W], seqLow};
    if (accept) begin
      if (startCyc && chipSel) begin
        stb.access  = 1'b1;
        stb.isWrite = ctrlStart && wrCond;
        accAddr     = addrIn;
      end else if (!startCyc && burstActive) begin
        stb.access  = 1'b1;
        stb.isWrite = wrCond;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snzSync     <= '0;
      burstActive <= 1'b0;
      burstBase   <= '0;
      burstCnt    <= '0;
    end else begin
      snzSync <= {snzSync[SNZ_STAGES-2:0], snooze};
      if (accept) begin
        if (startCyc) begin
          if (chipSel) begin
            burstActive <= 1'b1;
            burstBase   <= addrIn;
            burstCnt    <= '0;
          end else begin
            burstActive <= 1'b0;
          end
        end else if (burstActive) begin
          burstCnt <= nextCnt;
        end
      end
    end
  end

  // R3: a processor-strobe start never becomes a write
  a_r3_proc_reads: assert property (@(posedge clk) disable iff (!rstN)
    (!sleeping && !procStrbN && !selAN) |-> !stb.isWrite);
  // R2: an unselecting strobe cycle closes the burst
  a_r2_deselect_closes: assert property (@(posedge clk) disable iff (!rstN)
    (!sleeping && !ctrlStrbN && procStrbN && !(!selAN && selB && !selCN)) |=> !burstActive);
  // R7: an advance cycle in an open burst steps the counter by one
  a_r7_advance_step: assert property (@(posedge clk) disable iff (!rstN)
    (!sleeping && procStrbN && ctrlStrbN && burstActive && !advN)
      |=> burstCnt == CNT_W'($past(burstCnt) + 1'b1));
  // R12: burst state is frozen while asleep
  a_r12_sleep_hold: assert property (@(posedge clk) disable iff (!rstN)
    sleeping |=> ($stable(burstActive) && $stable(burstCnt) && $stable(burstBase)));
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobes_t                stb,
  input  logic [ADDR_W-1:0]          accAddr,
  input  logic [LANES-1:0]           laneMask,
  input  logic [LANES*LANE_BITS-1:0] wrData,
  input  logic                       outEnN,
  input  logic                       snooze,
  input  logic                       sleeping,
  output logic [LANES*LANE_BITS-1:0] rdData,
  output logic                       rdValid
);
  localparam int DATA_W = LANES * LANE_BITS;
  localparam int DEPTH  = 1 << ADDR_W;

  ctlStrobes_t       stageQ;
  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  maskQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] outReg;
  logic              outValid;
  logic [DATA_W-1:0] mem [DEPTH];

  // expand lane enables to a per-bit mask (parity bit rides with its lane)
  for (genvar i = 0; i < LANES; i++) begin : gLaneMask
    assign bitMask[i*LANE_BITS +: LANE_BITS] = {LANE_BITS{maskQ[i]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ   <= '0;
      addrQ    <= '0;
      maskQ    <= '0;
      dataQ    <= '0;
      outValid <= 1'b0;
      outReg   <= '0;
    end else begin
      stageQ   <= stb;
      addrQ    <= accAddr;
      maskQ    <= laneMask;
      dataQ    <= wrData;
      outValid <= stageQ.access && !stageQ.isWrite;
      if (stageQ.access && !stageQ.isWrite) outReg <= mem[addrQ];
    end
  end

  always_ff @(posedge clk) begin
    if (stageQ.access && stageQ.isWrite)
      mem[addrQ] <= (mem[addrQ] & ~bitMask) | (dataQ & bitMask);
  end

  always_comb begin
    rdValid = outValid && !outEnN && !snooze && !sleeping;
    rdData  = rdValid ? outReg : '0;
  end

  // R6: valid data only follows a registered read one edge earlier
  a_r6_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(stageQ.access && !stageQ.isWrite));
  // R10: a write cycle in the pipeline never yields read data next
  a_r10_write_no_output: assert property (@(posedge clk) disable iff (!rstN)
    (stageQ.access && stageQ.isWrite) |=> !outValid);
  // R11: output enable high keeps the bus quiet
  a_r11_oe_blank: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> (rdData == '0));
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 9,
  parameter int CNT_W     = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          addrIn,
  input  logic                       selAN,
  input  logic                       selB,
  input  logic                       selCN,
  input  logic                       procStrbN,
  input  logic                       ctrlStrbN,
  input  logic                       advN,
  input  logic                       globalWrN,
  input  logic                       byteWrEnN,
  input  logic [LANES-1:0]           laneWrN,
  input  logic                       burstInterleave,
  input  logic                       outEnN,
  input  logic                       snooze,
  input  logic [LANES*LANE_BITS-1:0] wrData,
  output logic [LANES*LANE_BITS-1:0] rdData,
  output logic                       rdValid
);
  ctlStrobes_t       stb;
  logic [ADDR_W-1:0] accAddr;
  logic [LANES-1:0]  laneMask;
  logic              sleeping;

  sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .selAN(selAN), .selB(selB),
    .selCN(selCN), .procStrbN(procStrbN), .ctrlStrbN(ctrlStrbN), .advN(advN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .burstInterleave(burstInterleave), .snooze(snooze), .stb(stb),
    .accAddr(accAddr), .laneMask(laneMask), .sleeping(sleeping)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .accAddr(accAddr), .laneMask(laneMask),
    .wrData(wrData), .outEnN(outEnN), .snooze(snooze), .sleeping(sleeping),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/tb_sync_burst_sram.sv
`timescale 1ns/1ps
module tb_sync_burst_sram;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addrIn;
  logic selAN, selB, selCN, procStrbN, ctrlStrbN, advN;
  logic globalWrN, byteWrEnN, burstInterleave, outEnN, snooze;
  logic [3:0] laneWrN;
  logic [DW-1:0] wrData, rdData;
  logic rdValid;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sync_burst_sram dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .selAN(selAN), .selB(selB),
    .selCN(selCN), .procStrbN(procStrbN), .ctrlStrbN(ctrlStrbN), .advN(advN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneWrN(laneWrN),
    .burstInterleave(burstInterleave), .outEnN(outEnN), .snooze(snooze),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

  function automatic logic [DW-1:0] pat(input int a);
    return (DW'(a) * 36'h0_1234_5679) ^ 36'hC_3C3C_3C3C;
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic v, input logic [DW-1:0] d,
                     input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (v !== ev || d !== ed) begin
      fails++;
      $display("FAIL %s: rdValid=%b rdData=%h expected rdValid=%b rdData=%h",
               req, v, d, ev, ed);
    end
  endtask

  task automatic setIdle();
    procStrbN = 1; ctrlStrbN = 1; advN = 1; globalWrN = 1; byteWrEnN = 1;
    laneWrN = 4'hF; selAN = 0; selB = 1; selCN = 0; outEnN = 0;
  endtask

  task automatic doWrite(input int a, input logic [DW-1:0] d);
    setIdle(); ctrlStrbN = 0; addrIn = AW'(a); globalWrN = 0; wrData = d;
    step(); setIdle();
  endtask

  task automatic readCheck(input string req, input int a, input logic [DW-1:0] e);
    setIdle(); ctrlStrbN = 0; addrIn = AW'(a);
    step(); setIdle(); step();
    chk(req, rdValid, rdData, 1'b1, e);
  endtask

  task automatic testReset();
    chk("R1 reset state", rdValid, rdData, 1'b0, '0);
    setIdle(); step(); step();
    chk("R1 no burst after reset", rdValid, rdData, 1'b0, '0);
  endtask

  task automatic testFill();
    for (int a = 0; a < 32; a++) doWrite(a, pat(a));
    readCheck("R5 global write readback", 0, pat(0));
    readCheck("R6 read latency", 31, pat(31));
  endtask

  task automatic testLanes();
    logic [DW-1:0] m;
    m = {9'h0, 9'h1FF, 9'h0, 9'h1FF};
    setIdle(); ctrlStrbN = 0; addrIn = 5; byteWrEnN = 0; laneWrN = 4'b1010;
    wrData = '1; step(); setIdle();
    readCheck("R4 lanes 0 and 2 with parity", 5, (pat(5) & ~m) | m);
    setIdle(); ctrlStrbN = 0; addrIn = 6; byteWrEnN = 1; laneWrN = 4'b0000;
    wrData = '0; step(); setIdle();
    readCheck("R4 lane bits ignored without byte enable", 6, pat(6));
  endtask

  task automatic testProc();
    setIdle(); procStrbN = 0; addrIn = 7; globalWrN = 0; wrData = '0;
    step(); setIdle(); step();
    chk("R3 proc strobe reads despite write", rdValid, rdData, 1'b1, pat(7));
    readCheck("R3 memory unchanged after proc strobe", 7, pat(7));
  endtask

  task automatic testDeselect();
    readCheck("R2 select open burst", 3, pat(3));
    setIdle(); ctrlStrbN = 0; selB = 0; step(); setIdle(); step();
    chk("R2 deselect by selB", rdValid, rdData, 1'b0, '0);
    step();
    chk("R2 burst stays closed", rdValid, rdData, 1'b0, '0);
    readCheck("R2 reselect", 4, pat(4));
    setIdle(); ctrlStrbN = 0; selCN = 1; step(); setIdle(); step();
    chk("R2 deselect by selCN", rdValid, rdData, 1'b0, '0);
    setIdle(); selAN = 1; procStrbN = 0; addrIn = 9; step(); setIdle(); step();
    chk("R3 proc strobe masked by selAN", rdValid, rdData, 1'b0, '0);
  endtask

  task automatic runBurst(input string req, input int base, input bit il,
                          input int e0, input int e1, input int e2, input int e3,
                          input logic [3:0] advMask);
    int exp[4];
    exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3;
    burstInterleave = il;
    for (int i = 0; i < 4; i++) begin
      setIdle();
      if (i == 0) begin ctrlStrbN = 0; addrIn = AW'(base); end
      else advN = !advMask[i];
      step();
      if (i > 0) chk(req, rdValid, rdData, 1'b1, pat(exp[i-1]));
    end
    setIdle(); step();
    chk(req, rdValid, rdData, 1'b1, pat(exp[3]));
    burstInterleave = 0;
  endtask

  task automatic testBursts();
    runBurst("R7 linear wrap", 10, 0, 10, 11, 8, 9, 4'b1110);
    runBurst("R8 interleave order", 9, 1, 9, 8, 11, 10, 4'b1110);
    runBurst("R9 suspend holds address", 12, 0, 12, 12, 13, 14, 4'b1100);
  endtask

  task automatic testBurstWrite();
    logic [DW-1:0] w0, w1, w2;
    w0 = 36'h1_1111_1111; w1 = 36'h2_2222_2222; w2 = 36'h3_3333_3333;
    setIdle(); ctrlStrbN = 0; addrIn = 16; globalWrN = 0; wrData = w0; step();
    setIdle(); advN = 0; globalWrN = 0; wrData = w1; step();
    setIdle(); advN = 0; globalWrN = 0; wrData = w2; step();
    setIdle(); step();
    readCheck("R10 burst write first", 16, w0);
    readCheck("R10 burst write second", 17, w1);
    readCheck("R10 burst write third", 18, w2);
    readCheck("R10 neighbour untouched", 19, pat(19));
  endtask

  task automatic testOe();
    setIdle(); ctrlStrbN = 0; addrIn = 2; step();
    setIdle(); outEnN = 1; step();
    chk("R11 output enable blanks", rdValid, rdData, 1'b0, '0);
    outEnN = 0; #1;
    chk("R11 output enable restores", rdValid, rdData, 1'b1, pat(2));
    @(negedge clk);
  endtask

  task automatic testSnooze();
    setIdle(); snooze = 1; step(); step();
    chk("R12 outputs blank in snooze", rdValid, rdData, 1'b0, '0);
    setIdle(); ctrlStrbN = 0; addrIn = 20; globalWrN = 0; wrData = '0;
    step();
    snooze = 0; step(); step();
    setIdle(); step();
    readCheck("R12 writes ignored across snooze windows", 20, pat(20));
  endtask

  initial begin
    setIdle(); snooze = 0; burstInterleave = 0; addrIn = '0; wrData = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    testFill();
    testLanes();
    testProc();
    testDeselect();
    testBursts();
    testBurstWrite();
    testOe();
    testSnooze();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule